// File: doc/BRIEF.md
# Serial Pixel-Code Row Loader

This block takes per-pixel exposure codes arriving on a set of serial lanes and assembles them into row-wide words. Each lane has its own shift register. When sixteen bits have arrived on every lane with the enable held high, the lanes together form one row word. That word is placed on a column code bus, and the block then drives the load strobe of the row it belongs to.

Rows are filled in strict order, starting at row 0. The row strobe stays high for fifteen cycles. During that time the next row's bits are already being shifted in, so a continuous stream delivers one row every sixteen clocks. When the preload window of the last row ends, the block raises a single global strobe. That strobe moves every row's staged code into the active latches at once, and the row pointer returns to row 0 for the next frame. If the enable drops partway through a word, the block throws away the bits received so far.

Top module: `code_row_loader`

## Requirements
- R1: While reset is held and in the first cycles after it is released, `code_bus`, `load_row` and `load_global` are all zero.
- R2: A word completes when `data_en` has been high for sixteen consecutive sampled bits. `code_bus` shows that word from the cycle after the edge that samples the sixteenth bit. Lane j occupies bits [16j+15:16j], and the first bit received on the lane lands in bit 16j+15.
- R3: `code_bus` holds its value until the next word completes.
- R4: The load strobe of the current row rises one cycle after `code_bus` changes, which is two edges after the sixteenth bit is sampled.
- R5: Every row strobe stays high for exactly 15 consecutive cycles, and at most one bit of `load_row` is high at any time.
- R6: Completed words are assigned to rows 0, 1, …, ROWS-1 in order, one row per word.
- R7: In the cycle after the preload window of row ROWS-1 ends, `load_global` is high for exactly one cycle. The next completed word then goes to row 0.
- R8: A word cut short by `data_en` going low is discarded. `code_bus` does not change, no row strobe is raised, and the row pointer does not move.
- R9: With `data_en` held high continuously, consecutive rows are spaced sixteen cycles apart. The next word is shifted in while the current row's strobe is high, and the two preload windows never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lane_in | input | LANES (18) | Serial code bits, one per lane |
| data_en | input | 1 | High while valid code bits are present on the lanes |
| code_bus | output | LANES*BITS (288) | Row word driven onto the column lines |
| load_row | output | ROWS (8) | One-hot preload strobe, one bit per row |
| load_global | output | 1 | Single-cycle strobe that moves staged codes into the active latches |

## Verification
The bench models the pixel array as a register file. Each row is written while its strobe is high, and the whole array is copied when the global strobe fires. The result is then compared with the words that were sent.

The bench targets the following corner cases:
- Back-to-back words with no idle cycle. A design that lets preload windows overlap, or that is off by one in the stretch count, either writes two rows at once or latches the next row's code.
- Words cut off after 1 to 15 bits. A design that keeps the partial bits shifts every later row by one slot and fires the global strobe at the wrong time.
- The wrap after the last row. A design that does not clear its pointer writes frame two into the wrong rows.

// File: rtl/code_row_pkg.sv
package code_row_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_LOAD = 1'b1
  } seq_state_t;

endpackage

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_en,
  output logic word_done,
  output logic deser_stb
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          stb_q, stb_d;

  always_comb begin
    word_done = data_en && (cnt_q == CW'(BITS-1));
    cnt_d     = cnt_q;
    stb_d     = 1'b0;
    if (!data_en) begin
      cnt_d = '0;
    end else if (word_done) begin
      cnt_d = '0;
      stb_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign deser_stb = stb_q;

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !data_en |=> (cnt_q == '0) && !stb_q); // R8
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R2

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int BITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            cap_en,
  input  logic            bit_in,
  output logic [BITS-1:0] word_out
);
  logic [BITS-1:0] sh_q, sh_d;
  logic [BITS-1:0] cap_q, cap_d;

  always_comb begin
    sh_d  = sh_q;
    cap_d = cap_q;
    if (shift_en) sh_d = {sh_q[BITS-2:0], bit_in};
    if (cap_en) cap_d = {sh_q[BITS-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cap_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cap_q <= cap_d;
    end
  end

  assign word_out = cap_q;

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap_q)); // R3

endmodule

// File: rtl/row_sequencer.sv
module row_sequencer
  import code_row_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int PRE_LEN = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            deser_stb,
  output logic [ROWS-1:0] load_row,
  output logic            load_global
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int PW = $clog2(PRE_LEN + 1);

  seq_state_t    st_q, st_d;
  logic [PW-1:0] pre_q, pre_d;
  logic [RW-1:0] row_q, row_d;
  logic          glob_q, glob_d;

  always_comb begin
    st_d   = st_q;
    pre_d  = pre_q;
    row_d  = row_q;
    glob_d = 1'b0;
    if (deser_stb) begin
      st_d  = SEQ_LOAD;
      pre_d = PW'(PRE_LEN);
    end else if (st_q == SEQ_LOAD) begin
      if (pre_q == PW'(1)) begin
        st_d  = SEQ_IDLE;
        pre_d = '0;
        if (row_q == RW'(ROWS-1)) begin
          row_d  = '0;
          glob_d = 1'b1;
        end else begin
          row_d = row_q + RW'(1);
        end
      end else begin
        pre_d = pre_q - PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      pre_q  <= '0;
      row_q  <= '0;
      glob_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pre_q  <= pre_d;
      row_q  <= row_d;
      glob_q <= glob_d;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign load_row[r] = (st_q == SEQ_LOAD) && (row_q == RW'(r));
  end

  assign load_global = glob_q;

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_row)); // R5
  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    deser_stb |=> (load_row != '0)); // R4
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    deser_stb |-> (load_row == '0)); // R9
  AST_GLOB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_global |=> !load_global); // R7
  AST_GLOB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    load_global |-> (row_q == '0) && (load_row == '0)); // R7

endmodule

// File: rtl/code_row_loader.sv
module code_row_loader #(
  parameter int LANES   = 18,
  parameter int BITS    = 16,
  parameter int ROWS    = 8,
  parameter int PRE_LEN = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      lane_in,
  input  logic                  data_en,
  output logic [LANES*BITS-1:0] code_bus,
  output logic [ROWS-1:0]       load_row,
  output logic                  load_global
);
  localparam int WORD_W = LANES * BITS;

  logic [1:0] rsync_q;
  logic       rst_core_n;
  logic       word_done;
  logic       deser_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  bit_timer #(.BITS(BITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .data_en  (data_en),
    .word_done(word_done),
    .deser_stb(deser_stb)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    lane_shifter #(.BITS(BITS)) u_lane (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .shift_en(data_en),
      .cap_en  (word_done),
      .bit_in  (lane_in[j]),
      .word_out(code_bus[j*BITS +: BITS])
    );
  end

  row_sequencer #(.ROWS(ROWS), .PRE_LEN(PRE_LEN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .deser_stb  (deser_stb),
    .load_row   (load_row),
    .load_global(load_global)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_core_n |-> (load_row == '0) && !load_global && (code_bus == WORD_W'(0))); // R1

endmodule

// File: tb/sim_code_row_loader.sv
module sim_code_row_loader;
  localparam int LANES = 18;
  localparam int BITS  = 16;
  localparam int ROWS  = 8;
  localparam int PRE   = 15;
  localparam int W     = LANES * BITS;
  localparam int MAXC  = 4096;

  logic             clk;
  logic             rst_n;
  logic [LANES-1:0] lane_in;
  logic             data_en;
  logic [W-1:0]     code_bus;
  logic [ROWS-1:0]  load_row;
  logic             load_global;

  code_row_loader #(.LANES(LANES), .BITS(BITS), .ROWS(ROWS), .PRE_LEN(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .data_en(data_en),
    .code_bus(code_bus), .load_row(load_row), .load_global(load_global)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int n     = 0;
  int row_exp = 0;

  logic [W-1:0]    exp_code [MAXC];
  logic            exp_cv   [MAXC];
  logic [ROWS-1:0] exp_load [MAXC];
  logic            exp_glob [MAXC];
  logic [W-1:0]    staged_exp [ROWS];
  logic [W-1:0]    frame_exp  [ROWS];
  logic [W-1:0]    pix_stage  [ROWS];
  logic [W-1:0]    pix_active [ROWS];

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", req, n, act, expv);
    end
  endtask

  // Advance one cycle; compare outputs and update the pixel array model.
  task automatic step();
    @(negedge clk);
    n++;
    if (n < MAXC) begin
      chk(load_row == exp_load[n], "R4/R5/R6/R9 load_row", W'(load_row), W'(exp_load[n]));
      chk(load_global == exp_glob[n], "R7 load_global", W'(load_global), W'(exp_glob[n]));
      if (exp_cv[n]) chk(code_bus == exp_code[n], "R2/R3/R8 code_bus", code_bus, exp_code[n]);
    end
    for (int r = 0; r < ROWS; r++) if (load_row[r]) pix_stage[r] = code_bus;
    if (load_global) for (int r = 0; r < ROWS; r++) pix_active[r] = pix_stage[r];
  endtask

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] w;
    for (int k = 0; k < W; k += 32) w[k +: 32] = $urandom();
    return w;
  endfunction

  // Expected outcome of a word whose last bit is driven in cycle c.
  task automatic expect_word(input int c, input logic [W-1:0] w);
    for (int k = c + 1; k < MAXC; k++) begin
      exp_code[k] = w;
      exp_cv[k]   = 1'b1;
    end
    for (int k = c + 2; k <= c + 1 + PRE; k++) exp_load[k] = ROWS'(1) << row_exp;
    staged_exp[row_exp] = w;
    if (row_exp == ROWS - 1) begin
      exp_glob[c + 2 + PRE] = 1'b1;
      for (int r = 0; r < ROWS; r++) frame_exp[r] = staged_exp[r];
      row_exp = 0;
    end else begin
      row_exp++;
    end
  endtask

  task automatic drive_bits(input logic [W-1:0] w, input int nb);
    for (int b = 0; b < nb; b++) begin
      step();
      data_en = 1'b1;
      for (int j = 0; j < LANES; j++) lane_in[j] = w[j*BITS + BITS - 1 - b];
    end
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      step();
      data_en = 1'b0;
      lane_in = LANES'($urandom());
    end
  endtask

  task automatic send_word(input logic [W-1:0] w);
    drive_bits(w, BITS);
    expect_word(n, w);
  endtask

  // R8: abort after nb bits (1..BITS-1); nothing may be registered
  task automatic send_partial(input int nb);
    drive_bits(rand_word(), nb);
    idle(1);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < MAXC; k++) begin
      exp_code[k] = '0; exp_cv[k] = 1'b0; exp_load[k] = '0; exp_glob[k] = 1'b0;
    end
    for (int r = 0; r < ROWS; r++) begin
      pix_stage[r] = '0; pix_active[r] = '0; frame_exp[r] = '0; staged_exp[r] = '0;
    end
    rst_n   = 1'b0;
    data_en = 1'b0;
    lane_in = '0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(code_bus == '0 && load_row == '0 && !load_global, "R1 reset", code_bus, '0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) exp_cv[k] = 1'b1;
    idle(4);
    // R1: quiet after release
    chk(code_bus == '0 && load_row == '0 && !load_global, "R1 after release", code_bus, '0);

    // Frame 1 (R9): continuous stream, directed patterns first
    send_word({W{1'b1}});
    send_word({(W/2){2'b10}});
    for (int r = 2; r < ROWS; r++) send_word(rand_word());
    idle(20);
    for (int r = 0; r < ROWS; r++)
      chk(pix_active[r] == frame_exp[r], "R6/R7 frame1 active row", pix_active[r], frame_exp[r]);

    // Frame 2 (R8): aborted words including 1 and 15 bits, random gaps
    send_partial(BITS - 1);
    send_word(rand_word());
    send_partial(1);
    for (int r = 1; r < ROWS; r++) begin
      if ($urandom_range(0, 2) == 0) send_partial($urandom_range(1, BITS - 1));
      send_word(rand_word());
      idle($urandom_range(0, 3));
    end
    idle(20);
    for (int r = 0; r < ROWS; r++)
      chk(pix_active[r] == frame_exp[r], "R6/R7/R8 frame2 active row", pix_active[r], frame_exp[r]);

    // Frames 3 and 4: random mix, frame boundary crossed back to back (R7 wrap)
    for (int r = 0; r < 2 * ROWS; r++) begin
      if ($urandom_range(0, 3) == 0) send_partial($urandom_range(1, BITS - 1));
      send_word(rand_word());
      if ($urandom_range(0, 1) == 0) idle($urandom_range(1, 5));
    end
    idle(25);
    for (int r = 0; r < ROWS; r++)
      chk(pix_active[r] == frame_exp[r], "R6/R7 frame4 active row", pix_active[r], frame_exp[r]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule